// File: doc/BRIEF.md
# Bit-Slice Integer ALU

This block is a purely combinational integer arithmetic logic unit assembled from identical one-bit cells. Each cell holds a full adder and a four-way output selector. Each cell can also invert either of its operand bits on the way in. One ripple carry chain runs through all cells. Addition, subtraction and the signed compare all use that chain. The bitwise AND, OR and NOR functions bypass it.

A 4-bit control word sets the function. Bit 3 inverts operand A in every cell. Bit 2 inverts operand B in every cell and is also the carry into cell 0. Bits 1:0 select the cell output: 00 is AND, 01 is OR, 10 is sum, 11 is the less-than input. Only six control words are defined. Any other word forces the result to zero.

The signed less-than decision is computed at the top cell and fed into cell 0. The result of the subtraction, a zero flag, the carry out of the top cell and a signed overflow flag are all visible on the ports. A datapath uses the zero flag after a subtraction to test two operands for equality.

Top module: `slice_alu`

## Requirements
- R1: Control 0000 gives result = op_a AND op_b, bit by bit.
- R2: Control 0001 gives result = op_a OR op_b, bit by bit.
- R3: Control 0010 gives result = (op_a + op_b) mod 2^32, and carry_out is bit 32 of the unsigned sum.
- R4: Control 0110 gives result = (op_a - op_b) mod 2^32, formed as op_a + NOT op_b + 1. carry_out is 1 exactly when op_a >= op_b as unsigned numbers.
- R5: Control 0111 sets result bit 0 to 1 when op_a < op_b as signed two's complement numbers and to 0 otherwise; result bits 31:1 are 0. The decision stays correct when the subtraction overflows, for example op_a = 0x80000000 with op_b = 0x7FFFFFFF.
- R6: Control 1100 gives result = NOT (op_a OR op_b), formed as (NOT op_a) AND (NOT op_b).
- R7: zero is 1 exactly when all 32 result bits are 0, for every control word.
- R8: Any control word other than 0000, 0001, 0010, 0110, 0111 and 1100 gives a result of all zeros, and therefore zero = 1.
- R9: For controls 0010 and 0110, overflow is 1 exactly when the signed two's complement result of that addition or subtraction does not fit in 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| alu_ctl | input | 4 | Function select: bit 3 inverts A, bit 2 inverts B and is the carry-in, bits 1:0 pick the cell output |
| result | output | 32 | Function result |
| zero | output | 1 | High when result is all zeros |
| carry_out | output | 1 | Carry out of the top cell |
| overflow | output | 1 | Signed overflow of the top-cell addition |

## Verification
The hardest case to reach is a signed compare whose subtraction overflows. The sign of the difference then gives the wrong answer, and only the overflow correction restores the right one. Random operands rarely hit it, because they need opposite signs and a large magnitude at the same time. The stimulus therefore crosses every defined control word with a set of extreme operands: zero, one, all ones, the largest positive value and the most negative value. This forces the overflow cases of add, subtract and compare directly. Random pairs and every undefined control word follow.

// File: rtl/alu_pkg.sv
// Package: shared widths and control-word encodings for the bit-slice ALU.
// Assumes the 4-bit control layout {invert_a, invert_b, select[1:0]}.
package alu_pkg;
    localparam int CTL_W = 4;
    localparam int SEL_W = 2;

    typedef enum logic [CTL_W-1:0] {
        CTL_AND  = 4'b0000,
        CTL_OR   = 4'b0001,
        CTL_ADD  = 4'b0010,
        CTL_SUB  = 4'b0110,
        CTL_SLT  = 4'b0111,
        CTL_NOR  = 4'b1100
    } alu_ctl_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } cell_sel_e;
endpackage

// File: rtl/alu_ctl_decode.sv
// Module: alu_ctl_decode
// Splits the control word into the per-cell controls and flags control words
// outside the defined set. Assumes the encodings in alu_pkg.
module alu_ctl_decode
    import alu_pkg::*;
(
    input  logic [CTL_W-1:0] ctl,
    output logic             inv_a,
    output logic             inv_b,
    output cell_sel_e        sel,
    output logic             legal
);
    // Field extraction: the bit positions are the control contract.
    always_comb begin
        inv_a = ctl[3];
        inv_b = ctl[2];
        sel   = cell_sel_e'(ctl[1:0]);
    end

    // Legal-word check: only the six defined functions are accepted.
    always_comb begin
        unique case (ctl)
            CTL_AND, CTL_OR, CTL_ADD,
            CTL_SUB, CTL_SLT, CTL_NOR: legal = 1'b1;
            default:                   legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_bit_slice.sv
// Module: alu_bit_slice
// One ALU cell: optional inversion of each operand bit, a full adder, and a
// four-way output selector (and / or / sum / less). Assumes the caller feeds
// the less input (only cell 0 receives a non-zero value).
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic      a,
    input  logic      b,
    input  logic      inv_a,
    input  logic      inv_b,
    input  logic      cin,
    input  logic      less,
    input  cell_sel_e sel,
    output logic      res,
    output logic      sum,
    output logic      cout
);
    logic a_eff;
    logic b_eff;

    // Operand conditioning: invert A and/or B as the control asks.
    always_comb begin
        a_eff = a ^ inv_a;
        b_eff = b ^ inv_b;
    end

    // Full adder: three-input parity and majority carry.
    always_comb begin
        sum  = a_eff ^ b_eff ^ cin;
        cout = (a_eff & b_eff) | (a_eff & cin) | (b_eff & cin);
    end

    // Output selector.
    always_comb begin
        unique case (sel)
            SEL_AND:  res = a_eff & b_eff;
            SEL_OR:   res = a_eff | b_eff;
            SEL_SUM:  res = sum;
            SEL_LESS: res = less;
            default:  res = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_zero_detect.sv
// Module: alu_zero_detect
// Reports whether a vector is all zeros using a NOR reduction.
// Assumes WIDTH >= 1.
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] vec,
    output logic             is_zero
);
    // Reduction: high when no bit is set.
    always_comb is_zero = ~|vec;
endmodule

// File: rtl/slice_alu.sv
// Module: slice_alu (top)
// Combinational integer ALU made of WIDTH replicated cells on one ripple carry
// chain. The signed less-than decision (sum sign xor overflow) is taken at the
// top cell and routed into cell 0. Undefined control words force the result to
// zero. Assumes WIDTH >= 2.
module slice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [CTL_W-1:0] alu_ctl,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             carry_out,
    output logic             overflow
);
    localparam int MSB = WIDTH - 1;

    logic             inv_a;
    logic             inv_b;
    cell_sel_e        sel;
    logic             legal;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] cell_res;
    logic [WIDTH-1:0] cell_sum;
    logic             signed_less;

    alu_ctl_decode u_dec (
        .ctl   (alu_ctl),
        .inv_a (inv_a),
        .inv_b (inv_b),
        .sel   (sel),
        .legal (legal)
    );

    // Carry-in: inverting B plus one is the two's complement negation.
    always_comb carry[0] = inv_b;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_cell
            logic less_in;
            if (i == 0) begin : g_lsb
                assign less_in = signed_less;
            end else begin : g_upper
                assign less_in = 1'b0;
            end
            alu_bit_slice u_cell (
                .a     (op_a[i]),
                .b     (op_b[i]),
                .inv_a (inv_a),
                .inv_b (inv_b),
                .cin   (carry[i]),
                .less  (less_in),
                .sel   (sel),
                .res   (cell_res[i]),
                .sum   (cell_sum[i]),
                .cout  (carry[i+1])
            );
        end
    endgenerate

    // Top-cell flags: carry, signed overflow, overflow-corrected sign.
    always_comb begin
        carry_out   = carry[WIDTH];
        overflow    = carry[WIDTH] ^ carry[MSB];
        signed_less = cell_sum[MSB] ^ overflow;
    end

    // Output gating: undefined control words give zero.
    always_comb result = legal ? cell_res : '0;

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .vec     (result),
        .is_zero (zero)
    );

    // Checks placed beside the cell chain and the output gating.
    always_comb begin
        if (legal) begin
            assert_chain_matches_adder_R3: assert (cell_sum ==
                ((op_a ^ {WIDTH{inv_a}}) + (op_b ^ {WIDTH{inv_b}}) + {{(WIDTH-1){1'b0}}, inv_b}))
                else $error("ripple chain disagrees with arithmetic sum");
        end
        if (alu_ctl == CTL_SLT) begin
            assert_slt_upper_clear_R5: assert (result[MSB:1] == '0)
                else $error("compare result has upper bits set");
            assert_slt_signed_R5: assert (result[0] == ($signed(op_a) < $signed(op_b)))
                else $error("signed compare wrong");
        end
        if (alu_ctl == CTL_NOR) begin
            assert_nor_value_R6: assert (result == ~(op_a | op_b))
                else $error("nor result wrong");
        end
        if (!legal) begin
            assert_illegal_zero_R8: assert (result == '0 && zero)
                else $error("undefined control word produced data");
        end
        if (alu_ctl == CTL_ADD) begin
            assert_add_overflow_R9: assert (overflow ==
                ((op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB])))
                else $error("add overflow flag wrong");
        end
    end
endmodule

// File: tb/slice_alu_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected items, the monitor pops and
// compares them at the falling clock edge after the inputs settle.
module slice_alu_tb;
    import alu_pkg::*;

    localparam int W = 32;

    typedef struct {
        logic [3:0]   ctl;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] res;
        logic         zf;
        logic         cf;
        logic         vf;
        logic         arith;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [3:0]   alu_ctl = 4'b0000;
    logic [W-1:0] result;
    logic         zero;
    logic         carry_out;
    logic         overflow;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    slice_alu #(.WIDTH(W)) u_dut (
        .op_a      (op_a),
        .op_b      (op_b),
        .alu_ctl   (alu_ctl),
        .result    (result),
        .zero      (zero),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    function automatic exp_t model(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
        exp_t e;
        logic [W:0] wide;
        e.ctl = c; e.a = a; e.b = b; e.arith = 1'b0; e.cf = 1'b0; e.vf = 1'b0;
        case (c)
            4'b0000: begin e.res = a & b;    e.req = "R1"; end
            4'b0001: begin e.res = a | b;    e.req = "R2"; end
            4'b0010: begin
                wide = {1'b0, a} + {1'b0, b};
                e.res = wide[W-1:0]; e.cf = wide[W]; e.arith = 1'b1;
                e.vf = (a[W-1] == b[W-1]) && (e.res[W-1] != a[W-1]);
                e.req = "R3/R9";
            end
            4'b0110: begin
                e.res = a - b; e.cf = (a >= b); e.arith = 1'b1;
                e.vf = (a[W-1] != b[W-1]) && (e.res[W-1] != a[W-1]);
                e.req = "R4/R9";
            end
            4'b0111: begin
                e.res = ($signed(a) < $signed(b)) ? 1 : 0; e.req = "R5";
            end
            4'b1100: begin e.res = ~(a | b); e.req = "R6"; end
            default: begin e.res = '0;       e.req = "R8"; end
        endcase
        e.zf = (e.res == '0);
        return e;
    endfunction

    task automatic drive(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        alu_ctl = c; op_a = a; op_b = b;
        sb.push_back(model(c, a, b));
    endtask

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s ctl=%b a=%h b=%h actual=%h expected=%h", req, alu_ctl, op_a, op_b, act, exp_v);
        end
    endtask

    // Monitor: compare the item pushed at the preceding rising edge.
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            check(result == e.res, e.req, result, e.res);
            check(zero == e.zf, "R7", {31'b0, zero}, {31'b0, e.zf});
            if (e.arith) begin
                check(carry_out == e.cf, e.req, {31'b0, carry_out}, {31'b0, e.cf});
                check(overflow == e.vf, "R9", {31'b0, overflow}, {31'b0, e.vf});
            end
        end
    end

    initial begin
        logic [W-1:0] corners [5];
        logic [3:0]   ops [6];
        corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
        corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h7FFF_FFFF;
        corners[4] = 32'h8000_0000;
        ops[0] = CTL_AND; ops[1] = CTL_OR; ops[2] = CTL_ADD;
        ops[3] = CTL_SUB; ops[4] = CTL_SLT; ops[5] = CTL_NOR;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-state check: all-zero inputs give a zero AND result (R1, R7).
        drive(CTL_AND, '0, '0);
        // Extreme operands crossed with every defined function.
        for (int o = 0; o < 6; o++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    drive(ops[o], corners[i], corners[j]);
        // Equality through subtraction (R4, R7).
        drive(CTL_SUB, 32'h1234_5678, 32'h1234_5678);
        // Random operand pairs.
        for (int n = 0; n < 400; n++)
            drive(ops[n % 6], $urandom, $urandom);
        // Every undefined control word with non-zero operands (R8).
        for (int c = 0; c < 16; c++)
            drive(4'(c), 32'hA5A5_F00F, 32'h5A5A_0FF1);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule